// File: doc/BRIEF.md
# Log-Domain Accumulate Unit

This unit adds a new term to a running sum that is kept as a logarithm. Given the running value `acc` and a new term `term`, both log-probabilities, it returns `acc + ln(1 + e^(term - acc))`. That is the logarithm of the sum of the two linear-domain quantities. The softplus correction is not computed with exponentials. It is looked up in a 64-bin table of constants that covers differences from -8.0 to just under +8.0. Outside that window one of two asymptotic shortcuts applies. When the new term is far below the running sum, the result is the running sum. When the new term is far above it, the result is the new term.

All values are 16-bit two's-complement numbers with 8 fractional bits, so one unit equals 256 LSB. The code 16'h8000 is reserved as a "log of zero" marker. A scoring engine feeds one operation per clock and gets each result two cycles later. It can therefore chain many accumulations back to back without stalls.

Top module: `logadd_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_sum` is 0, whatever is on `in_valid`, `in_acc` and `in_term`.
- R2: An operation presented with `in_valid` high during clock cycle n appears on `out_sum` with `out_valid` high during cycle n+2. A new operation is accepted every cycle. `out_valid` is low two cycles after any cycle with `in_valid` low.
- R3: Values are signed with 8 fractional bits (value = code/256). With neither operand equal to 16'h8000, let d = term - acc in LSB. If -2048 <= d <= 2047, the result is acc + T[i], where i = floor((d + 2048) / 64) and T[i] = round(256 * ln(1 + e^x)) with x = -7.875 + 0.25*i, the centre of bin i.
- R4: With neither operand the marker, if d < -2048 the result equals `in_acc` exactly.
- R5: With neither operand the marker, if d >= 2048 the result equals `in_term` exactly.
- R6: If `in_acc` is 16'h8000 the result equals `in_term`. Otherwise, if `in_term` is 16'h8000 the result equals `in_acc`. This takes precedence over R3 to R5, and two markers give 16'h8000.
- R7: When acc + T[i] exceeds 32767 LSB, the result is clamped to 16'h7FFF.
- R8: In the table window the result is never below `in_acc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `in_acc` and `in_term` are to be processed this cycle |
| in_acc | input | 16 | Running log-domain sum, signed Q8.8 |
| in_term | input | 16 | New log-domain term, signed Q8.8 |
| out_valid | output | 1 | `out_sum` carries a result this cycle |
| out_sum | output | 16 | Updated log-domain sum, signed Q8.8 |

## Verification
There are three kinds of internal fault to catch. A wrong bin index or a wrong table constant changes `out_sum` by at least one LSB for any difference that falls in that bin. A wrong region decision shows up at the window edges: at d = 2047 against d = 2048 it makes a difference of 31 LSB. A wrong marker priority shows up as a result near -32538 instead of the exact other operand. Every one of these faults is visible on the result exactly two cycles after the operands enter. A fault in the stage-valid chain shows up in the same cycle as a missing or extra `out_valid` pulse around an idle gap in a back-to-back stream.

// File: rtl/logadd_pkg.sv
package logadd_pkg;

  localparam int unsigned VAL_W    = 16;  // operand and result width
  localparam int unsigned FRAC_W   = 8;   // fractional bits
  localparam int unsigned IDX_W    = 6;   // table index width (64 bins)
  localparam int unsigned SPAN_INT = 8;   // window half-width in integer units

  localparam int unsigned DIFF_W    = VAL_W + 2;                 // room for diff plus offset
  localparam int          HALF_SPAN = SPAN_INT << FRAC_W;        // 2048 LSB
  localparam int unsigned WIN_W     = $clog2(2 * HALF_SPAN);     // 12 bits of window offset
  localparam int unsigned BIN_SHIFT = WIN_W - IDX_W;             // 64 LSB per bin
  localparam int          HALF_BIN  = 1 << (BIN_SHIFT - 1);      // centre offset of a bin
  localparam int unsigned HALF_IDX  = IDX_W - 1;

  localparam logic [VAL_W-1:0] VAL_MIN = {1'b1, {(VAL_W-1){1'b0}}};
  localparam logic [VAL_W-1:0] VAL_MAX = {1'b0, {(VAL_W-1){1'b1}}};

  typedef enum logic [1:0] {
    RG_TABLE = 2'd0,
    RG_ACC   = 2'd1,
    RG_TERM  = 2'd2
  } region_e;

  typedef struct packed {
    region_e          region;
    logic [VAL_W-1:0] acc;
    logic [VAL_W-1:0] term;
    logic [VAL_W-1:0] corr;
  } stage_t;

  // Correction for the lower half of the window, bins centred at -7.875 .. -0.125,
  // value round(256 * ln(1 + e^x)).
  function automatic logic [VAL_W-1:0] low_half(input logic [HALF_IDX-1:0] j);
    logic [VAL_W-1:0] r;
    case (j)
      5'd7, 5'd8, 5'd9, 5'd10: r = 16'd1;
      5'd11, 5'd12, 5'd13:     r = 16'd2;
      5'd14: r = 16'd3;
      5'd15: r = 16'd4;
      5'd16: r = 16'd5;
      5'd17: r = 16'd7;
      5'd18: r = 16'd9;
      5'd19: r = 16'd11;
      5'd20: r = 16'd14;
      5'd21: r = 16'd18;
      5'd22: r = 16'd23;
      5'd23: r = 16'd29;
      5'd24: r = 16'd37;
      5'd25: r = 16'd46;
      5'd26: r = 16'd58;
      5'd27: r = 16'd72;
      5'd28: r = 16'd89;
      5'd29: r = 16'd110;
      5'd30: r = 16'd134;
      5'd31: r = 16'd162;
      default: r = 16'd0;
    endcase
    return r;
  endfunction

  // Full 64-bin correction. The upper half follows from softplus(x) = x + softplus(-x),
  // and the mirror of bin k in the lower half is bin ~k.
  function automatic logic [VAL_W-1:0] corr_entry(input logic [IDX_W-1:0] idx);
    logic [HALF_IDX-1:0] k;
    logic [VAL_W-1:0]    centre;
    k = idx[HALF_IDX-1:0];
    if (!idx[IDX_W-1]) return low_half(k);
    centre = VAL_W'(HALF_BIN) + (VAL_W'(k) << BIN_SHIFT);
    return centre + low_half(~k);
  endfunction

  function automatic logic signed [VAL_W:0] wide_sum(input logic [VAL_W-1:0] acc,
                                                     input logic [VAL_W-1:0] corr);
    return $signed({acc[VAL_W-1], acc}) + $signed({1'b0, corr});
  endfunction

  function automatic logic [VAL_W-1:0] clamp(input logic signed [VAL_W:0] w);
    if (w > $signed({1'b0, VAL_MAX})) return VAL_MAX;
    if (w < $signed({1'b1, VAL_MIN})) return VAL_MIN;
    return w[VAL_W-1:0];
  endfunction

endpackage

// File: rtl/logadd_classify.sv
module logadd_classify
  import logadd_pkg::*;
(
  input  logic [VAL_W-1:0] acc,
  input  logic [VAL_W-1:0] term,
  output region_e          region,
  output logic [IDX_W-1:0] bin_idx,
  output logic             acc_marker,
  output logic             term_marker,
  output logic             far_below,
  output logic             far_above
);

  logic [DIFF_W-1:0] offset;

  // offset = (term - acc) + HALF_SPAN, so the window maps to [0, 2*HALF_SPAN)
  always_comb begin
    offset = {{(DIFF_W-VAL_W){term[VAL_W-1]}}, term}
           - {{(DIFF_W-VAL_W){acc[VAL_W-1]}}, acc}
           + DIFF_W'(HALF_SPAN);
  end

  assign acc_marker  = (acc == VAL_MIN);
  assign term_marker = (term == VAL_MIN);
  assign far_below   = offset[DIFF_W-1];
  assign far_above   = !offset[DIFF_W-1] && (|offset[DIFF_W-2:WIN_W]);
  assign bin_idx     = offset[WIN_W-1:BIN_SHIFT];

  always_comb begin
    if (acc_marker)       region = RG_TERM;
    else if (term_marker) region = RG_ACC;
    else if (far_below)   region = RG_ACC;
    else if (far_above)   region = RG_TERM;
    else                  region = RG_TABLE;
  end

endmodule

// File: rtl/logadd_corr_rom.sv
module logadd_corr_rom
  import logadd_pkg::*;
(
  input  logic [IDX_W-1:0] bin_idx,
  output logic [VAL_W-1:0] corr
);

  assign corr = corr_entry(bin_idx);

endmodule

// File: rtl/logadd_merge.sv
module logadd_merge
  import logadd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  stage_t           s1,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_sum
);

  logic signed [VAL_W:0] raw_sum;
  logic                  sat_hit;

  assign raw_sum = wide_sum(s1.acc, s1.corr);
  assign sat_hit = s1_valid && (s1.region == RG_TABLE) && (raw_sum > $signed({1'b0, VAL_MAX}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        case (s1.region)
          RG_ACC:  out_sum <= s1.acc;
          RG_TERM: out_sum <= s1.term;
          default: out_sum <= clamp(raw_sum);
        endcase
      end
    end
  end

  // R7
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> (out_sum == VAL_MAX));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

endmodule

// File: rtl/logadd_unit.sv
module logadd_unit
  import logadd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VAL_W-1:0] in_acc,
  input  logic [VAL_W-1:0] in_term,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_sum
);

  region_e          region;
  logic [IDX_W-1:0] bin_idx;
  logic [VAL_W-1:0] corr;
  logic             acc_marker, term_marker, far_below, far_above;
  logic             s1_valid;
  stage_t           s1;

  logadd_classify u_classify (
    .acc         (in_acc),
    .term        (in_term),
    .region      (region),
    .bin_idx     (bin_idx),
    .acc_marker  (acc_marker),
    .term_marker (term_marker),
    .far_below   (far_below),
    .far_above   (far_above)
  );

  logadd_corr_rom u_rom (
    .bin_idx (bin_idx),
    .corr    (corr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1       <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1.region <= region;
        s1.acc    <= in_acc;
        s1.term   <= in_term;
        s1.corr   <= corr;
      end
    end
  end

  logadd_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1        (s1),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  logic plain_op;
  assign plain_op = in_valid && !acc_marker && !term_marker;

  // R2
  stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R2
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R6
  acc_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_marker) |=> ##1 (out_sum == $past(in_term, 2)));

  // R6
  term_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && term_marker && !acc_marker) |=> ##1 (out_sum == $past(in_acc, 2)));

  // R4
  far_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_op && far_below) |=> ##1 (out_sum == $past(in_acc, 2)));

  // R5
  far_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_op && far_above) |=> ##1 (out_sum == $past(in_term, 2)));

  // R8
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_op && !far_below && !far_above) |=> ##1
      ($signed(out_sum) >= $signed($past(in_acc, 2))));

endmodule

// File: tb/test_logadd_unit.sv
module test_logadd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_acc = '0;
  logic [15:0] in_term = '0;
  logic        out_valid;
  logic [15:0] out_sum;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logadd_unit i_logadd_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_acc    (in_acc),
    .in_term   (in_term),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  // Expected value taken from the requirement text, using real arithmetic.
  function automatic int expect_sum(int a, int b);
    int d, bin, c, s;
    real xc;
    if (a == -32768) return b;          // R6
    if (b == -32768) return a;          // R6
    d = b - a;
    if (d < -2048) return a;            // R4
    if (d >= 2048) return b;            // R5
    bin = (d + 2048) / 64;              // R3
    xc  = -7.875 + 0.25 * bin;
    c   = $rtoi(256.0 * $ln(1.0 + $exp(xc)) + 0.5);
    s   = a + c;
    if (s > 32767) s = 32767;           // R7
    return s;
  endfunction

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive one operation, wait two cycles, compare.
  task automatic one_op(string req, int a, int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_acc   = 16'(a);
    in_term  = 16'(b);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'($signed(out_sum)), expect_sum(a, b));
  endtask

  task automatic test_reset();
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_acc   = 16'd100;
    in_term  = 16'd200;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_sum in reset", int'(out_sum), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", int'(out_valid), 0);
  endtask

  task automatic test_table_sweep();
    for (int i = 0; i < 64; i++) begin
      one_op("R3 sweep low-in-bin", -1000, -1000 - 2048 + 64 * i + (i * 7) % 64);
    end
    for (int i = 0; i < 64; i++) begin
      one_op("R3 sweep bin-top", 5000, 5000 - 2048 + 64 * i + 63);
    end
    // R8: results inside window never drop below acc
    one_op("R8 table floor", 300, 300 - 2048);
    check("R8 floor value", int'($signed(out_sum)) >= 300 ? 1 : 0, 1);
  endtask

  task automatic test_edges();
    one_op("R3 window top d=2047", 0, 2047);
    one_op("R5 window exit d=2048", 0, 2048);
    one_op("R5 far above", -20000, 15000);
    one_op("R4 window exit d=-2049", 1000, 1000 - 2049);
    one_op("R4 far below", 25000, -30000);
    one_op("R3 window bottom d=-2048", -500, -2548);
  endtask

  task automatic test_markers();
    one_op("R6 acc marker near", -32768, -32700);
    one_op("R6 acc marker", -32768, 1234);
    one_op("R6 term marker near", -32700, -32768);
    one_op("R6 term marker", -77, -32768);
    one_op("R6 both markers", -32768, -32768);
  endtask

  task automatic test_saturation();
    one_op("R7 clamp top", 32767, 32767);
    one_op("R7 clamp near", 32700, 32760);
    one_op("R7 no clamp", 32000, 32767);
  endtask

  task automatic test_stream();
    int sa[20];
    int sb[20];
    bit sv[20];
    for (int i = 0; i < 20; i++) begin
      sa[i] = -3000 + 311 * i;
      sb[i] = sa[i] + (i * 257) % 4500 - 2250;
      sv[i] = (i != 9) && (i != 14);
    end
    sa[5] = -32768;
    sb[12] = -32768;
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R2 stream valid", int'(out_valid), int'(sv[i-2]));
        if (sv[i-2]) check("R2 stream result", int'($signed(out_sum)), expect_sum(sa[i-2], sb[i-2]));
      end
      if (i < 20) begin
        in_valid = sv[i];
        in_acc   = 16'(sa[i]);
        in_term  = 16'(sb[i]);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    test_reset();
    test_table_sweep();
    test_edges();
    test_markers();
    test_saturation();
    test_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule